// File: doc/BRIEF.md
# Dual-Address Port-Expander Serial Slave

This block is a two-wire serial bus slave that gives a host access to eight input ports and eight push-pull output ports. It answers on two 7-bit addresses. The upper three address bits pick the port group, and a 4-bit select value supplied from outside the block fills in the lower four bits. The bus clock and data lines are first synchronised and then glitch-filtered. START and STOP conditions are recognised at any point. The block shifts address and data bits, acknowledges on an open-drain data line, and sends read data back to the host.

For the input group, the block keeps a snapshot of the ports and a sticky flag for every port that has changed since the last access. A write to this group loads an interrupt mask. A read returns the port levels and the flags alternately. The ports are resampled and the flags cleared at the acknowledge that comes before each port byte. An active-low interrupt reports masked changes. It is held off from the moment an input-group access is acknowledged until that transaction ends. For the output group, each written byte updates all eight outputs together, and each read byte returns a fresh sample of the levels actually present on the output pins.

Top module: `pex_i2c_slave`

## Requirements
- R1: Address byte bits [7:1] equal to {3'b110, addr_sel} select the input group and {3'b101, addr_sel} the output group; bit 0 is 1 for read and 0 for write. A matching address is acknowledged by driving SDA low during the ninth clock. Any other address is never acknowledged, and the slave then stays silent until the next START.
- R2: Every data byte written to the output group is acknowledged and drives all eight bits of out_port at once. out_port changes at no other time.
- R3: Every data byte written to the input group is acknowledged and replaces the interrupt mask. A bit of 1 in the mask lets that port's flag drive the interrupt, and a 0 blocks it. Bit i of every port or flag byte belongs to in_port[i].
- R4: A read of the input group returns as its first byte the in_port levels sampled at the address acknowledge, and as its second byte the flags as they stood at that sample. Sampling clears the flags.
- R5: In a longer input read, bytes keep alternating port and flag. Each port byte is resampled, and the flags are captured and cleared, at the host acknowledge that precedes it. Changes made between samples appear in the following flag byte.
- R6: Every byte read from the output group is the out_pin value sampled at the acknowledge just before that byte.
- R7: A port's flag is set whenever its input differs from the snapshot, and stays set even if the input returns to its old level.
- R8: irq_n goes low when a flag whose mask bit is 1 is set and no input-group access is in progress. An acknowledged input-group access drives irq_n high until STOP. If a change arrives during that access and is not read out before STOP, irq_n goes low again after STOP.
- R9: After rst_n the outputs equal OUT_RESET (8'hFF), the mask is 8'hFF, the flags are clear, irq_n is high and SDA is released.
- R10: When the host does not acknowledge a read byte, the slave releases SDA and ignores all further clocks until STOP or START.
- R11: Holding bus_rst_n low aborts any transaction in the next cycle and releases SDA. The slave then waits for a new START. bus_rst_n does not change irq_n.
- R12: A pulse on SCL shorter than FILT_LEN system clocks is ignored and does not add a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of all state |
| bus_rst_n | input | 1 | Active-low transaction abort |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 4 | Lower four address bits for both groups |
| in_port | input | 8 | Monitored input ports |
| out_pin | input | 8 | Levels present on the output pins |
| out_port | output | 8 | Output port latch |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A line change on the bus takes two synchroniser stages, FILT_LEN filter samples, one edge register and one state register to become visible, about seven system clocks with the defaults. A port change appears in the flags one clock later and in irq_n two clocks later. The bench drives the bus with quarter-bit spacing of twelve clocks and samples SDA in the middle of the high phase, so each acknowledge and data bit is read well after it has settled. The out_port reference is compared on every clock, and the previous value is allowed only while a written byte is still in flight. Checks on irq_n wait several clocks after each port change or STOP.

// File: rtl/pex_pkg.sv
package pex_pkg;

    localparam int BYTE_W = 8;
    localparam logic [2:0] IN_GRP_PREFIX  = 3'b110;
    localparam logic [2:0] OUT_GRP_PREFIX = 3'b101;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_ADDR,
        PS_ADDR_END,
        PS_ADDR_ACK,
        PS_WR,
        PS_WR_END,
        PS_WR_ACK,
        PS_RD,
        PS_RD_ACK,
        PS_WAIT
    } pex_state_e;

    typedef struct packed {
        pex_state_e          st;
        logic [2:0]          cnt;
        logic [BYTE_W-1:0]   sh;
        logic [BYTE_W-1:0]   outp;
        logic                sda_oe;
        logic                grp_in;
        logic                rd;
        logic                odd;
        logic                hold;
        logic                scl_p;
        logic                sda_p;
    } pex_ctl_t;

endpackage

// File: rtl/pex_glitch_filter.sv
module pex_glitch_filter #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    typedef struct packed {
        logic [SYNC_LEN-1:0] sync;
        logic [FILT_LEN-1:0] win;
        logic                lvl;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[SYNC_LEN-2:0], raw};
        flt_d.win  = {flt_q.win[FILT_LEN-2:0], flt_q.sync[SYNC_LEN-1]};
        if (&flt_q.win)
            flt_d.lvl = 1'b1;
        else if (~|flt_q.win)
            flt_d.lvl = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flt_q <= '1;
        else
            flt_q <= flt_d;
    end

    assign filt = flt_q.lvl;
endmodule

// File: rtl/pex_in_monitor.sv
module pex_in_monitor #(
    parameter int          PORT_W     = 8,
    parameter logic [7:0]  MASK_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] in_port,
    input  logic              sample_stb,
    input  logic              mask_we,
    input  logic [PORT_W-1:0] mask_data,
    input  logic              hold,
    output logic [PORT_W-1:0] flag_cap,
    output logic              irq_n
);
    typedef struct packed {
        logic [PORT_W-1:0] snap;
        logic [PORT_W-1:0] flags;
        logic [PORT_W-1:0] cap;
        logic [PORT_W-1:0] mask;
        logic              irq;
    } mon_t;

    mon_t mon_d, mon_q;
    logic [PORT_W-1:0] chg;

    always_comb begin
        mon_d     = mon_q;
        chg       = in_port ^ mon_q.snap;
        mon_d.flags = mon_q.flags | chg;
        if (sample_stb) begin
            mon_d.cap   = mon_q.flags | chg;
            mon_d.snap  = in_port;
            mon_d.flags = '0;
        end
        if (mask_we)
            mon_d.mask = mask_data;
        mon_d.irq = !hold && (|(mon_q.flags & mon_q.mask));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q      <= '0;
            mon_q.mask <= MASK_RESET[PORT_W-1:0];
        end else begin
            mon_q <= mon_d;
        end
    end

    assign flag_cap = mon_q.cap;
    assign irq_n    = !mon_q.irq;
endmodule

// File: rtl/pex_i2c_slave.sv
module pex_i2c_slave
    import pex_pkg::*;
#(
    parameter int         SYNC_LEN   = 2,
    parameter int         FILT_LEN   = 3,
    parameter logic [7:0] OUT_RESET  = 8'hFF,
    parameter logic [7:0] MASK_RESET = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [3:0]  addr_sel,
    input  logic [7:0]  in_port,
    input  logic [7:0]  out_pin,
    output logic [7:0]  out_port,
    output logic        irq_n
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        pex_glitch_filter #(
            .SYNC_LEN(SYNC_LEN),
            .FILT_LEN(FILT_LEN)
        ) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[g]),
            .filt (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    pex_ctl_t ctl_d, ctl_q;

    logic              sample_stb, mask_we, out_we;
    logic              bus_start, bus_stop, scl_rise, scl_fall;
    logic              hit_in, hit_out;
    logic [BYTE_W-1:0] nxt_byte;
    logic [BYTE_W-1:0] flag_cap;

    always_comb begin
        bus_start = scl_f && ctl_q.scl_p && ctl_q.sda_p && !sda_f;
        bus_stop  = scl_f && ctl_q.scl_p && !ctl_q.sda_p && sda_f;
        scl_rise  = scl_f && !ctl_q.scl_p;
        scl_fall  = !scl_f && ctl_q.scl_p;
        hit_in    = ctl_q.sh[7:1] == {IN_GRP_PREFIX, addr_sel};
        hit_out   = ctl_q.sh[7:1] == {OUT_GRP_PREFIX, addr_sel};
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.scl_p = scl_f;
        ctl_d.sda_p = sda_f;
        sample_stb  = 1'b0;
        mask_we     = 1'b0;
        out_we      = 1'b0;
        nxt_byte    = '0;

        if (!bus_rst_n || bus_stop) begin
            ctl_d.st     = PS_IDLE;
            ctl_d.sda_oe = 1'b0;
            ctl_d.hold   = 1'b0;
        end else if (bus_start) begin
            ctl_d.st     = PS_ADDR;
            ctl_d.cnt    = '0;
            ctl_d.sda_oe = 1'b0;
        end else begin
            case (ctl_q.st)
                PS_ADDR: begin
                    if (scl_rise) begin
                        ctl_d.sh  = {ctl_q.sh[BYTE_W-2:0], sda_f};
                        ctl_d.cnt = ctl_q.cnt + 3'd1;
                        if (ctl_q.cnt == 3'd7)
                            ctl_d.st = PS_ADDR_END;
                    end
                end
                PS_ADDR_END: begin
                    if (scl_fall) begin
                        if (hit_in || hit_out) begin
                            ctl_d.st     = PS_ADDR_ACK;
                            ctl_d.sda_oe = 1'b1;
                            ctl_d.grp_in = hit_in;
                            ctl_d.rd     = ctl_q.sh[0];
                            ctl_d.odd    = 1'b0;
                            if (hit_in) begin
                                sample_stb = 1'b1;
                                ctl_d.hold = 1'b1;
                            end
                            if (ctl_q.sh[0])
                                ctl_d.sh = hit_in ? in_port : out_pin;
                        end else begin
                            ctl_d.st = PS_IDLE;
                        end
                    end
                end
                PS_ADDR_ACK: begin
                    if (scl_fall) begin
                        ctl_d.cnt    = '0;
                        ctl_d.st     = ctl_q.rd ? PS_RD : PS_WR;
                        ctl_d.sda_oe = ctl_q.rd && !ctl_q.sh[BYTE_W-1];
                    end
                end
                PS_WR: begin
                    if (scl_rise) begin
                        ctl_d.sh  = {ctl_q.sh[BYTE_W-2:0], sda_f};
                        ctl_d.cnt = ctl_q.cnt + 3'd1;
                        if (ctl_q.cnt == 3'd7)
                            ctl_d.st = PS_WR_END;
                    end
                end
                PS_WR_END: begin
                    if (scl_fall) begin
                        if (ctl_q.grp_in) begin
                            mask_we = 1'b1;
                        end else begin
                            out_we     = 1'b1;
                            ctl_d.outp = ctl_q.sh;
                        end
                        ctl_d.sda_oe = 1'b1;
                        ctl_d.st     = PS_WR_ACK;
                    end
                end
                PS_WR_ACK: begin
                    if (scl_fall) begin
                        ctl_d.sda_oe = 1'b0;
                        ctl_d.cnt    = '0;
                        ctl_d.st     = PS_WR;
                    end
                end
                PS_RD: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == 3'd7) begin
                            ctl_d.sda_oe = 1'b0;
                            ctl_d.st     = PS_RD_ACK;
                        end else begin
                            ctl_d.sh     = {ctl_q.sh[BYTE_W-2:0], 1'b0};
                            ctl_d.sda_oe = !ctl_q.sh[BYTE_W-2];
                            ctl_d.cnt    = ctl_q.cnt + 3'd1;
                        end
                    end
                end
                PS_RD_ACK: begin
                    if (scl_rise && sda_f) begin
                        ctl_d.st = PS_WAIT;
                    end else if (scl_fall) begin
                        ctl_d.odd = !ctl_q.odd;
                        if (!ctl_q.grp_in) begin
                            nxt_byte = out_pin;
                        end else if (!ctl_q.odd) begin
                            nxt_byte = flag_cap;
                        end else begin
                            nxt_byte   = in_port;
                            sample_stb = 1'b1;
                        end
                        ctl_d.sh     = nxt_byte;
                        ctl_d.sda_oe = !nxt_byte[BYTE_W-1];
                        ctl_d.cnt    = '0;
                        ctl_d.st     = PS_RD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= PS_IDLE;
            ctl_q.outp  <= OUT_RESET;
            ctl_q.scl_p <= 1'b1;
            ctl_q.sda_p <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pex_in_monitor #(
        .PORT_W    (BYTE_W),
        .MASK_RESET(MASK_RESET)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_port   (in_port),
        .sample_stb(sample_stb),
        .mask_we   (mask_we),
        .mask_data (ctl_q.sh),
        .hold      (ctl_q.hold),
        .flag_cap  (flag_cap),
        .irq_n     (irq_n)
    );

    assign sda_oe   = ctl_q.sda_oe;
    assign out_port = ctl_q.outp;
endmodule

// File: rtl/pex_checker.sv
module pex_checker
    import pex_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rst_n,
    input logic       sda_oe,
    input pex_state_e st,
    input logic       out_we,
    input logic [7:0] out_port,
    input logic       sample_stb,
    input logic       mask_we,
    input logic       grp_in,
    input logic       hold,
    input logic       irq_n
);
    // R11
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> !sda_oe);

    // R8
    irq_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> irq_n);

    // R2
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_we |=> $stable(out_port));

    // R1
    drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (st == PS_ADDR_ACK || st == PS_WR_ACK || st == PS_RD));

    // R4
    sample_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> grp_in);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_stb, mask_we, out_we}));

    // R10
    nack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_WAIT) |-> !sda_oe);
endmodule

bind pex_i2c_slave pex_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst_n (bus_rst_n),
    .sda_oe    (sda_oe),
    .st        (ctl_q.st),
    .out_we    (out_we),
    .out_port  (out_port),
    .sample_stb(sample_stb),
    .mask_we   (mask_we),
    .grp_in    (ctl_q.grp_in),
    .hold      (ctl_q.hold),
    .irq_n     (irq_n)
);

// File: tb/tb_pex_i2c_slave.sv
`timescale 1ns/1ps
module tb_pex_i2c_slave;
    localparam int Q  = 12;
    localparam int H  = 24;
    localparam int WATCHDOG = 150000;
    localparam logic [3:0] SEL = 4'b0101;
    localparam logic [6:0] A_IN  = {3'b110, SEL};
    localparam logic [6:0] A_OUT = {3'b101, SEL};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst_n = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [7:0] in_port = 8'h00;
    logic [7:0] out_pin = 8'h00;
    logic [7:0] out_port;
    logic irq_n;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] out_exp = 8'hFF;
    logic [7:0] out_alt = 8'hFF;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    pex_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(SEL), .in_port(in_port), .out_pin(out_pin),
        .out_port(out_port), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R2: out_port follows the reference on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (out_port !== out_exp && out_port !== out_alt) begin
                n_fail++;
                $display("FAIL R2 out_port actual=%0h expected=%0h", out_port, out_exp);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b1; wclk(Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b; wclk(Q);
        scl_m = 1'b1;
        if (glitch) begin
            wclk(H/2); scl_m = 1'b0; wclk(2); scl_m = 1'b1; wclk(H/2 - 2);
        end else begin
            wclk(H);
        end
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(H/2);
        b = sda_line; wclk(H/2);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input int glitch_bit, output bit ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i], i == glitch_bit);
        recv_bit(x);
        ack = !x;
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    endtask

    task automatic set_in(input logic [7:0] v);
        in_port = v;
        wclk(6);
    endtask

    task automatic wr_out(input logic [7:0] v, input int glitch_bit, input string tag);
        bit ack;
        out_alt = v;
        send_byte(v, glitch_bit, ack);
        check(ack, {tag, " data ack"}, ack, 1);
        out_exp = v;
        wclk(2);
        check(out_port == v, {tag, " out_port"}, out_port, v);
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        wclk(4);
        rst_n = 1'b1;
        wclk(10);

        // R9 reset state
        check(out_port == 8'hFF, "R9 out_port reset", out_port, 8'hFF);
        check(irq_n == 1'b1, "R9 irq_n reset", irq_n, 1);
        check(sda_oe == 1'b0, "R9 sda released", sda_oe, 0);

        // R1 R2 output-group write, two bytes
        i2c_start();
        send_byte({A_OUT, 1'b0}, -1, ack);
        check(ack, "R1 output address ack", ack, 1);
        wr_out(8'hA5, -1, "R2");
        wr_out(8'h3C, -1, "R2");
        i2c_stop();

        // R1 foreign address ignored
        i2c_start();
        send_byte({7'h44, 1'b0}, -1, ack);
        check(!ack, "R1 foreign address no ack", ack, 0);
        send_byte(8'h00, -1, ack);
        check(!ack, "R1 foreign data no ack", ack, 0);
        i2c_stop();

        // R6 output-group read returns pin levels, fresh per byte
        out_pin = 8'h81;
        i2c_start();
        send_byte({A_OUT, 1'b1}, -1, ack);
        check(ack, "R1 output read ack", ack, 1);
        recv_byte(b);
        check(b == 8'h81, "R6 first pin byte", b, 8'h81);
        out_pin = 8'h7E;
        send_bit(1'b0, 1'b0);
        recv_byte(b);
        check(b == 8'h7E, "R6 second pin byte", b, 8'h7E);
        send_bit(1'b1, 1'b0);
        i2c_stop();

        // R7 R8 flags and interrupt
        set_in(8'h01);
        check(irq_n == 1'b0, "R8 irq on masked change", irq_n, 0);
        set_in(8'h05);
        set_in(8'h01);

        // R4 two-byte input read
        i2c_start();
        send_byte({A_IN, 1'b1}, -1, ack);
        check(ack, "R1 input read ack", ack, 1);
        wclk(2);
        check(irq_n == 1'b1, "R8 irq cleared at ack", irq_n, 1);
        recv_byte(b);
        check(b == 8'h01, "R4 port byte", b, 8'h01);
        send_bit(1'b0, 1'b0);
        recv_byte(b);
        check(b == 8'h05, "R7 sticky transient flag", b, 8'h05);
        send_bit(1'b1, 1'b0);
        i2c_stop();
        wclk(6);
        check(irq_n == 1'b1, "R4 flags cleared", irq_n, 1);

        // R8 hold-off during an input access
        i2c_start();
        send_byte({A_IN, 1'b1}, -1, ack);
        set_in(8'h09);
        check(irq_n == 1'b1, "R8 held off in access", irq_n, 1);
        recv_byte(b);
        check(b == 8'h01, "R4 port byte before change", b, 8'h01);
        send_bit(1'b1, 1'b0);
        wclk(4);
        check(irq_n == 1'b1, "R8 still held before STOP", irq_n, 1);
        i2c_stop();
        wclk(6);
        check(irq_n == 1'b0, "R8 reassert after STOP", irq_n, 0);

        // R5 long read alternates and resamples
        i2c_start();
        send_byte({A_IN, 1'b1}, -1, ack);
        recv_byte(b);
        check(b == 8'h09, "R5 byte0 port", b, 8'h09);
        send_bit(1'b0, 1'b0);
        set_in(8'h19);
        recv_byte(b);
        check(b == 8'h08, "R5 byte1 flags", b, 8'h08);
        send_bit(1'b0, 1'b0);
        recv_byte(b);
        check(b == 8'h19, "R5 byte2 resampled port", b, 8'h19);
        send_bit(1'b0, 1'b0);
        recv_byte(b);
        check(b == 8'h10, "R5 byte3 new flags", b, 8'h10);
        send_bit(1'b1, 1'b0);
        i2c_stop();
        wclk(6);
        check(irq_n == 1'b1, "R5 nothing pending after long read", irq_n, 1);

        // R3 mask writes
        i2c_start();
        send_byte({A_IN, 1'b0}, -1, ack);
        send_byte(8'h00, -1, ack);
        check(ack, "R3 mask byte ack", ack, 1);
        i2c_stop();
        set_in(8'h18);
        check(irq_n == 1'b1, "R3 mask zero blocks irq", irq_n, 1);
        i2c_start();
        send_byte({A_IN, 1'b0}, -1, ack);
        send_byte(8'hFF, -1, ack);
        send_byte(8'h01, -1, ack);
        check(ack, "R3 second mask byte ack", ack, 1);
        i2c_stop();
        set_in(8'h1A);
        check(irq_n == 1'b1, "R3 unmasked bit1 blocked", irq_n, 1);
        set_in(8'h1B);
        check(irq_n == 1'b0, "R3 mask bit0 passes", irq_n, 0);

        // R10 NACK releases the bus
        i2c_start();
        send_byte({A_IN, 1'b1}, -1, ack);
        recv_byte(b);
        check(b == 8'h1B, "R4 port byte", b, 8'h1B);
        send_bit(1'b1, 1'b0);
        recv_byte(b);
        check(b == 8'hFF, "R10 silent after NACK", b, 8'hFF);
        i2c_stop();
        wclk(6);
        check(irq_n == 1'b1, "R8 cleared by access", irq_n, 1);

        // R11 bus reset aborts during acknowledge, irq untouched
        set_in(8'h1A);
        check(irq_n == 1'b0, "R7 flag sets irq", irq_n, 0);
        i2c_start();
        for (int i = 7; i >= 0; i--) send_bit(((A_OUT << 1) >> i) & 1, 1'b0);
        check(sda_oe == 1'b1, "R1 ack driven", sda_oe, 1);
        bus_rst_n = 1'b0; wclk(1); bus_rst_n = 1'b1;
        wclk(2);
        check(sda_oe == 1'b0, "R11 abort releases SDA", sda_oe, 0);
        check(irq_n == 1'b0, "R11 irq unchanged", irq_n, 0);
        i2c_start();
        send_byte({A_OUT, 1'b0}, -1, ack);
        check(ack, "R11 new transaction after abort", ack, 1);
        wr_out(8'h42, -1, "R11");
        i2c_stop();

        // R12 short SCL glitch ignored
        i2c_start();
        send_byte({A_OUT, 1'b0}, -1, ack);
        wr_out(8'h99, 4, "R12");
        i2c_stop();

        wclk(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule